// File: doc/BRIEF.md
# Ten-bit serializer with automatic idle fill

This block is the transmit end of a serial link that carries characters of ten bits each. The characters are already line-coded when they arrive. Once per word period the block samples a parallel character. It holds the character for one word period and then sends it out one bit per bit-clock cycle, with the most significant bit first. The block makes no change to the character's code.

One clock, `clk_i`, is the bit clock. A divide-by-ten counter derives the word period from it, and `word_tick_o` shows that period to the upstream logic. A character is taken on a word edge only if at least one of the two active-low enables is low at that edge. If both enables are high, the block puts a K28.5 comma into that slot instead. It picks the comma's polarity from a running-disparity flag, and it toggles the flag for every comma it inserts. User characters do not change the flag. The first comma after user data can therefore have the wrong polarity, but every comma after it in the run alternates correctly. The upstream encoder must make sure each character has at least one transition.

Top module: `pad_serializer`

## Requirements
- R1: While `rst_ni` is low, `ser_o`, `word_tick_o` and `rd_pos_o` are all 0, and the running disparity restarts as negative.
- R2: `word_tick_o` is high for exactly one cycle in every ten. It first rises in the tenth cycle after reset is released. The word edge is the rising edge of `clk_i` that ends a cycle in which `word_tick_o` is high.
- R3: At a word edge where `en_a_ni` or `en_b_ni` is low, `data_i` is captured exactly as given.
- R4: At a word edge where both enables are high, a comma is captured. It is 10'b0011111010 when `rd_pos_o` is 0 and 10'b1100000101 when `rd_pos_o` is 1. Bit 9 is sent first.
- R5: A character captured at one word edge is loaded into the shifter at the next word edge. Bit 9 appears on `ser_o` just after that edge, and bits 8 down to 0 follow, one per clock.
- R6: `rd_pos_o` inverts after each word edge that inserts a comma. It is unchanged after a word edge that takes user data, and it is unchanged in every other cycle.
- R7: If an enable is held low throughout, no comma is ever inserted, and `rd_pos_o` keeps its value.
- R8: Characters with no transitions, such as all zeros or all ones, pass through unaltered. The block does not enforce transition density.
- R9: After reset, `ser_o` stays 0 until the first captured character is loaded into the shifter. That first character is a negative-polarity comma unless an enable is low at the first word edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 10 | Pre-coded character, bit 9 sent first |
| en_a_ni | input | 1 | Take-data enable A, active low |
| en_b_ni | input | 1 | Take-data enable B, active low |
| ser_o | output | 1 | Serial bit stream |
| word_tick_o | output | 1 | High in the cycle that ends with a word edge |
| rd_pos_o | output | 1 | Running disparity flag, 1 means positive |

## Verification
The assertions assume that `data_i` and both enables are settled at the word edge. They assume that only the values at that edge matter. They also assume that reset is held low for at least one clock edge. The bench changes every input on the falling edge of the clock, so each rising edge samples a stable value. It also changes data and enables in cycles that are not word edges, so these show no effect. Reset is asserted on a falling edge and held for several cycles, once at the start and once in the middle of traffic.

// File: rtl/pad_ser_pkg.sv
package pad_ser_pkg;
  localparam int CHAR_W = 10;
  localparam int CNT_W  = $clog2(CHAR_W);
  typedef logic [CHAR_W-1:0] char_t;
  localparam char_t K285_NEG = 10'b0011111010;
  localparam char_t K285_POS = 10'b1100000101;
endpackage

// File: rtl/pad_ser_word_timer.sv
module pad_ser_word_timer #(
  parameter int DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = rst_ni && (cnt_q == LAST);
endmodule

// File: rtl/pad_ser_char_reg.sv
module pad_ser_char_reg
  import pad_ser_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  take_i,
  input  char_t data_i,
  output char_t hold_o,
  output logic  rd_pos_o
);
  char_t hold_q;
  logic  rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      rd_q   <= 1'b0;
    end else if (tick_i) begin
      if (take_i) begin
        hold_q <= data_i;
      end else begin
        hold_q <= rd_q ? K285_POS : K285_NEG;
        rd_q   <= ~rd_q;
      end
    end
  end

  assign hold_o   = hold_q;
  assign rd_pos_o = rd_q;
endmodule

// File: rtl/pad_ser_shifter.sv
module pad_ser_shifter
  import pad_ser_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  char_t par_i,
  output logic  ser_o
);
  char_t sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= par_i;
    else             sh_q <= {sh_q[CHAR_W-2:0], 1'b0};
  end

  assign ser_o = sh_q[CHAR_W-1];
endmodule

// File: rtl/pad_serializer.sv
module pad_serializer
  import pad_ser_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CHAR_W-1:0] data_i,
  input  logic              en_a_ni,
  input  logic              en_b_ni,
  output logic              ser_o,
  output logic              word_tick_o,
  output logic              rd_pos_o
);
  logic  tick;
  logic  take;
  char_t hold_q;

  assign take = ~en_a_ni | ~en_b_ni;

  pad_ser_word_timer #(.DIV(CHAR_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  pad_ser_char_reg u_char (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .take_i  (take),
    .data_i  (data_i),
    .hold_o  (hold_q),
    .rd_pos_o(rd_pos_o)
  );

  // shifter takes the previous capture on the same edge that captures the next
  pad_ser_shifter u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tick),
    .par_i (hold_q),
    .ser_o (ser_o)
  );

  assign word_tick_o = tick;
endmodule

// File: rtl/pad_serializer_chk.sv
module pad_serializer_chk
  import pad_ser_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  en_a_ni,
  input logic  en_b_ni,
  input logic  ser_o,
  input logic  word_tick_o,
  input logic  rd_pos_o,
  input char_t hold_i
);
  logic [CNT_W-1:0] gap_q;
  logic             pad;

  assign pad = en_a_ni & en_b_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gap_q <= '0;
    else if (word_tick_o) gap_q <= '0;
    else                  gap_q <= gap_q + 1'b1;
  end

  always_comb begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (!ser_o && !word_tick_o && !rd_pos_o);
    end
  end

  assert_tick_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_tick_o |-> gap_q == CNT_W'(CHAR_W - 1));

  assert_tick_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_tick_o |=> !word_tick_o);

  assert_pad_neg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_tick_o && pad && !rd_pos_o) |=> hold_i == K285_NEG);

  assert_pad_pos_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_tick_o && pad && rd_pos_o) |=> hold_i == K285_POS);

  assert_first_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_tick_o |=> ser_o == $past(hold_i[CHAR_W-1]));

  assert_rd_flip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_tick_o && pad) |=> rd_pos_o != $past(rd_pos_o));

  assert_rd_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_tick_o && pad) |=> $stable(rd_pos_o));
endmodule

bind pad_serializer pad_serializer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_a_ni    (en_a_ni),
  .en_b_ni    (en_b_ni),
  .ser_o      (ser_o),
  .word_tick_o(word_tick_o),
  .rd_pos_o   (rd_pos_o),
  .hold_i     (hold_q)
);

// File: tb/pad_serializer_tb.sv
module pad_serializer_tb;
  localparam int W = 10;
  localparam logic [W-1:0] KN = 10'b0011111010;
  localparam logic [W-1:0] KP = 10'b1100000101;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] data = '0;
  logic         en_a_n = 1'b1;
  logic         en_b_n = 1'b1;
  logic         ser, tick, rd_pos;

  int total = 0;
  int bad = 0;
  string cur_req = "R9";

  // behavioural model
  int           m_cnt = 0;
  logic [W-1:0] m_prev = '0;
  logic         m_rd = 1'b0;
  logic         m_ser = 1'b0;
  bit           bitq[$];

  pad_serializer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data),
    .en_a_ni(en_a_n), .en_b_ni(en_b_n),
    .ser_o(ser), .word_tick_o(tick), .rd_pos_o(rd_pos)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_prev = '0; m_rd = 1'b0; m_ser = 1'b0; bitq.delete();
    end else begin
      if (m_cnt == W - 1) begin
        for (int i = W - 1; i >= 0; i--) bitq.push_back(m_prev[i]);
        if (!en_a_n || !en_b_n) m_prev = data;
        else begin
          m_prev = m_rd ? KP : KN;
          m_rd = ~m_rd;
        end
        m_cnt = 0;
      end else m_cnt++;
      m_ser = (bitq.size() > 0) ? bitq.pop_front() : 1'b0;
    end
  end

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!rst_n) begin
      chk("R1 ser", ser, 1'b0);
      chk("R1 tick", tick, 1'b0);
      chk("R1 rd", rd_pos, 1'b0);
    end else begin
      chk({cur_req, " ser"}, ser, m_ser);
      chk("R2 tick", tick, (m_cnt == W - 1));
      chk("R6 rd", rd_pos, m_rd);
    end
  end

  logic [15:0] lfsr = 16'hACE1;

  // mode: 0 pads, 1 en_a low, 2 en_b low, 3 random enables, 4 both low, 5 flat patterns
  task automatic run(int n, int mode);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      data = lfsr[W-1:0];
      case (mode)
        0: begin en_a_n = 1'b1; en_b_n = 1'b1; end
        1: begin en_a_n = 1'b0; en_b_n = 1'b1; end
        2: begin en_a_n = 1'b1; en_b_n = 1'b0; end
        3: begin en_a_n = lfsr[11]; en_b_n = lfsr[14]; end
        4: begin en_a_n = 1'b0; en_b_n = 1'b0; end
        default: begin
          en_a_n = 1'b0; en_b_n = 1'b1;
          data = ((c / 7) % 2 == 1) ? '1 : '0;
        end
      endcase
    end
  endtask

  initial begin
    logic rd_before;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R9"; run(25, 0);
    cur_req = "R4"; run(60, 0);
    cur_req = "R3"; run(50, 1); run(50, 2);
    cur_req = "R5"; run(40, 1);
    cur_req = "R6"; run(300, 3);
    cur_req = "R8"; run(80, 5);
    cur_req = "R7";
    rd_before = rd_pos;
    run(120, 4);
    chk("R7 rd unchanged", rd_pos, rd_before);
    cur_req = "R6"; run(100, 3);
    // mid-traffic reset
    @(negedge clk); rst_n = 1'b0;
    run(4, 3);
    @(negedge clk); rst_n = 1'b1;
    cur_req = "R9"; run(30, 1);
    cur_req = "R6"; run(60, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule